// File: doc/BRIEF.md
# Hidden Address Register Tracker

This block keeps a copy of the internal 16-bit scratch address register of an 8-bit accumulator CPU. Programmers cannot read or write this register directly. Its value still leaks out through two undocumented flag bits after a bit test on memory addressed by HL, so an exact model of the core has to track it.

The block samples a one-cycle completion strobe. On the rising clock edge where the strobe is high, it loads a new value chosen by a 6-bit instruction-class code. The inputs to that choice are:
- the register values at instruction start,
- the immediate operands,
- the word read from the stack,
- four outcome flags.

Decoding, the ALU, memory and the visible register file sit outside the block. They supply the class code and the operands. The flag unit picks up bits 13 and 11 from the two tap outputs.

The design has two parts. A control module turns the class code and outcome flags into a load strobe and a source selector. A datapath module forms every candidate value and holds the register.

Top module: `haddr_tracker`

## Requirements
- R1: `hidAddr` is 0000h while `rstN` is low. It changes only on a rising `clk` edge with `done` high. With `done` low, or with a class code not listed below (including 0 and 35..63, which covers the non-repeating block copies), it keeps its value.
- R2: Class 1 (indexed memory access) loads `regIdx` plus `imm8` sign-extended to 16 bits.
- R3: Class 2 loads `regBC`+1, class 3 loads `regDE`+1, and classes 4 and 11 (8-bit and 16-bit loads or stores through an absolute address) load `imm16`+1. All of these are full 16-bit sums with carry.
- R4: Each of these loads `regA` into the high byte. The low byte is (byte + 1) mod 256 with no carry into the high byte:
  - class 5 uses the low byte of `regBC`;
  - class 6 uses the low byte of `regDE`;
  - class 7 uses the low byte of `imm16`;
  - class 8 (port output of A at an immediate port) uses `imm8`.
- R5: Class 9 (port input to A from an immediate port) loads ({`regA`,`imm8`}) + 1 as a 16-bit sum. Class 10 (port access through C) loads `regBC`+1.
- R6: The branch classes load as follows:
  - Class 12 (absolute jump or call) loads `imm16`, whatever the condition.
  - Class 13 (relative jump) loads `pcStart`+2+sign-extended `imm8`, but only when `condMet` is high.
  - Class 14 (decrement-and-branch) loads the same value, but only when `bZeroAfter` is low.
  - Otherwise these classes hold.
- R7: The stack and restart classes load as follows:
  - Class 15 (return) loads `stackWord`.
  - Class 16 (conditional return) loads `stackWord` only when `condMet` is high.
  - Class 18 (exchange with stack top) loads `stackWord`.
  - Class 17 (restart) loads the zero-extended `imm8` vector.
- R8: Classes 19 (16-bit add or subtract into HL) and 21 (nibble rotate through memory) load `regHL`+1. Class 20 (16-bit add into an index register) loads `regIdx`+1.
- R9: Class 22 adds 1 to the current value and class 23 subtracts 1. Classes 24 and 25 load `pcStart`+1 when the compare repeats, that is when `bcZeroAfter` is low and `cmpMatch` is low. Otherwise class 24 adds 1 and class 25 subtracts 1.
- R10: Class 26 (repeating block copy) loads `pcStart`+1 when `bcZeroAfter` is low and holds otherwise.
- R11: The block input and output classes load as follows:
  - Class 27 loads `regBC`+1 and class 28 loads `regBC`-1.
  - Class 31 loads `bcAfter`+1 and class 32 loads `bcAfter`-1.
  - Repeating forms 29, 30, 33 and 34 load `pcStart`+1 when `bZeroAfter` is low. Otherwise they follow classes 27, 28, 31 and 32 respectively.
- R12: `flagBit5` always equals bit 13 of `hidAddr` and `flagBit3` always equals bit 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| done | input | 1 | Instruction-complete strobe |
| cls | input | 6 | Instruction-class code |
| regA | input | 8 | Accumulator at instruction start |
| regBC | input | 16 | BC at instruction start |
| regDE | input | 16 | DE at instruction start |
| regHL | input | 16 | HL at instruction start |
| regIdx | input | 16 | Selected index register at instruction start |
| pcStart | input | 16 | Address of the instruction's first byte |
| imm8 | input | 8 | Displacement, relative offset, port number or restart vector |
| imm16 | input | 16 | Absolute address or jump target |
| stackWord | input | 16 | Word read from the stack top |
| bcAfter | input | 16 | BC after the instruction |
| condMet | input | 1 | Condition held |
| bZeroAfter | input | 1 | B is zero after the instruction |
| bcZeroAfter | input | 1 | BC is zero after the instruction |
| cmpMatch | input | 1 | Block compare found a match |
| hidAddr | output | 16 | Hidden address register |
| flagBit5 | output | 1 | Tap of register bit 13 |
| flagBit3 | output | 1 | Tap of register bit 11 |

## Verification
The hardest cases to reach are the rules that depend on state, not just on operands: the compare classes step the register's own current value, and the conditional classes must leave it untouched. The bench sweeps every one of the 64 class codes against all 16 combinations of outcome flags. It also cycles through operand patterns that sit on byte and word wrap points (FFh low bytes, 7Fh/80h offsets, FFFFh addresses), so the register itself drifts across carry and borrow boundaries before the stepping classes act on it. After every update, the bench holds `done` low for one cycle while it scrambles the operands, to show that the held value survives.

// File: rtl/haddr_pkg.sv
package haddr_pkg;
  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;
  localparam int CLS_W  = 6;
  localparam int EXT_W  = ADDR_W - BYTE_W;
  localparam int TAP_HI = 13;
  localparam int TAP_LO = 11;

  typedef enum logic [CLS_W-1:0] {
    CLS_HOLD      = 6'd0,
    CLS_IDX_DISP  = 6'd1,
    CLS_LDA_BC    = 6'd2,
    CLS_LDA_DE    = 6'd3,
    CLS_LDA_ABS   = 6'd4,
    CLS_STA_BC    = 6'd5,
    CLS_STA_DE    = 6'd6,
    CLS_STA_ABS   = 6'd7,
    CLS_OUT_PORT  = 6'd8,
    CLS_IN_PORT   = 6'd9,
    CLS_IO_C      = 6'd10,
    CLS_LD16_ABS  = 6'd11,
    CLS_JP_ABS    = 6'd12,
    CLS_JR_REL    = 6'd13,
    CLS_DJNZ      = 6'd14,
    CLS_RET       = 6'd15,
    CLS_RET_CC    = 6'd16,
    CLS_RST       = 6'd17,
    CLS_EX_SP     = 6'd18,
    CLS_ADD_HL    = 6'd19,
    CLS_ADD_IDX   = 6'd20,
    CLS_NIB_ROT   = 6'd21,
    CLS_CMP_INC   = 6'd22,
    CLS_CMP_DEC   = 6'd23,
    CLS_CMP_INC_R = 6'd24,
    CLS_CMP_DEC_R = 6'd25,
    CLS_COPY_R    = 6'd26,
    CLS_INB_INC   = 6'd27,
    CLS_INB_DEC   = 6'd28,
    CLS_INB_INC_R = 6'd29,
    CLS_INB_DEC_R = 6'd30,
    CLS_OUTB_INC  = 6'd31,
    CLS_OUTB_DEC  = 6'd32,
    CLS_OUTB_INC_R= 6'd33,
    CLS_OUTB_DEC_R= 6'd34
  } clsCode_e;

  typedef enum logic [4:0] {
    SRC_IDX_DISP  = 5'd0,
    SRC_BC_INC    = 5'd1,
    SRC_BC_DEC    = 5'd2,
    SRC_DE_INC    = 5'd3,
    SRC_IMM_INC   = 5'd4,
    SRC_IMM       = 5'd5,
    SRC_ACC_C     = 5'd6,
    SRC_ACC_E     = 5'd7,
    SRC_ACC_IMMLO = 5'd8,
    SRC_ACC_PORT  = 5'd9,
    SRC_PORT_INC  = 5'd10,
    SRC_REL       = 5'd11,
    SRC_STACK     = 5'd12,
    SRC_VEC       = 5'd13,
    SRC_HL_INC    = 5'd14,
    SRC_IDX_INC   = 5'd15,
    SRC_CUR_INC   = 5'd16,
    SRC_CUR_DEC   = 5'd17,
    SRC_PC_INC    = 5'd18,
    SRC_BCA_INC   = 5'd19,
    SRC_BCA_DEC   = 5'd20
  } srcSel_e;

  typedef struct packed {
    logic    load;
    srcSel_e src;
  } haddrCtl_t;

  function automatic logic [ADDR_W-1:0] sext8(input logic [BYTE_W-1:0] b);
    return {{EXT_W{b[BYTE_W-1]}}, b};
  endfunction
endpackage

// File: rtl/haddr_ctrl.sv
module haddr_ctrl
  import haddr_pkg::*;
(
  input  logic             done,
  input  logic [CLS_W-1:0] cls,
  input  logic             condMet,
  input  logic             bZeroAfter,
  input  logic             bcZeroAfter,
  input  logic             cmpMatch,
  output haddrCtl_t        ctl
);
  logic      enable;
  srcSel_e   src;
  logic      cmpRepeat;
  logic      bRepeat;
  logic      copyRepeat;

  assign cmpRepeat  = !bcZeroAfter && !cmpMatch;
  assign bRepeat    = !bZeroAfter;
  assign copyRepeat = !bcZeroAfter;

  always_comb begin
    enable = 1'b1;
    src    = SRC_CUR_INC;
    case (clsCode_e'(cls))
      CLS_IDX_DISP:   src = SRC_IDX_DISP;
      CLS_LDA_BC:     src = SRC_BC_INC;
      CLS_LDA_DE:     src = SRC_DE_INC;
      CLS_LDA_ABS,
      CLS_LD16_ABS:   src = SRC_IMM_INC;
      CLS_STA_BC:     src = SRC_ACC_C;
      CLS_STA_DE:     src = SRC_ACC_E;
      CLS_STA_ABS:    src = SRC_ACC_IMMLO;
      CLS_OUT_PORT:   src = SRC_ACC_PORT;
      CLS_IN_PORT:    src = SRC_PORT_INC;
      CLS_IO_C:       src = SRC_BC_INC;
      CLS_JP_ABS:     src = SRC_IMM;
      CLS_JR_REL: begin
        src    = SRC_REL;
        enable = condMet;
      end
      CLS_DJNZ: begin
        src    = SRC_REL;
        enable = bRepeat;
      end
      CLS_RET,
      CLS_EX_SP:      src = SRC_STACK;
      CLS_RET_CC: begin
        src    = SRC_STACK;
        enable = condMet;
      end
      CLS_RST:        src = SRC_VEC;
      CLS_ADD_HL,
      CLS_NIB_ROT:    src = SRC_HL_INC;
      CLS_ADD_IDX:    src = SRC_IDX_INC;
      CLS_CMP_INC:    src = SRC_CUR_INC;
      CLS_CMP_DEC:    src = SRC_CUR_DEC;
      CLS_CMP_INC_R:  src = cmpRepeat ? SRC_PC_INC : SRC_CUR_INC;
      CLS_CMP_DEC_R:  src = cmpRepeat ? SRC_PC_INC : SRC_CUR_DEC;
      CLS_COPY_R: begin
        src    = SRC_PC_INC;
        enable = copyRepeat;
      end
      CLS_INB_INC:    src = SRC_BC_INC;
      CLS_INB_DEC:    src = SRC_BC_DEC;
      CLS_INB_INC_R:  src = bRepeat ? SRC_PC_INC : SRC_BC_INC;
      CLS_INB_DEC_R:  src = bRepeat ? SRC_PC_INC : SRC_BC_DEC;
      CLS_OUTB_INC:   src = SRC_BCA_INC;
      CLS_OUTB_DEC:   src = SRC_BCA_DEC;
      CLS_OUTB_INC_R: src = bRepeat ? SRC_PC_INC : SRC_BCA_INC;
      CLS_OUTB_DEC_R: src = bRepeat ? SRC_PC_INC : SRC_BCA_DEC;
      default:        enable = 1'b0;
    endcase
  end

  assign ctl.load = done && enable;
  assign ctl.src  = src;

  always_comb begin
    if (!done) begin
      AST_IDLE_NO_LOAD: assert (!ctl.load); // R1
    end
  end
endmodule

// File: rtl/haddr_dpath.sv
module haddr_dpath
  import haddr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  haddrCtl_t         ctl,
  input  logic [BYTE_W-1:0] regA,
  input  logic [ADDR_W-1:0] regBC,
  input  logic [ADDR_W-1:0] regDE,
  input  logic [ADDR_W-1:0] regHL,
  input  logic [ADDR_W-1:0] regIdx,
  input  logic [ADDR_W-1:0] pcStart,
  input  logic [BYTE_W-1:0] imm8,
  input  logic [ADDR_W-1:0] imm16,
  input  logic [ADDR_W-1:0] stackWord,
  input  logic [ADDR_W-1:0] bcAfter,
  output logic [ADDR_W-1:0] hidAddr,
  output logic              flagBit5,
  output logic              flagBit3
);
  localparam logic [ADDR_W-1:0] ONE_W = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] TWO_W = ADDR_W'(2);
  localparam logic [BYTE_W-1:0] ONE_B = BYTE_W'(1);

  logic [ADDR_W-1:0] nextVal;
  logic [ADDR_W-1:0] accPort;
  logic [ADDR_W-1:0] relTarget;

  assign accPort   = {regA, imm8};
  assign relTarget = pcStart + TWO_W + sext8(imm8);

  always_comb begin
    case (ctl.src)
      SRC_IDX_DISP:  nextVal = regIdx + sext8(imm8);
      SRC_BC_INC:    nextVal = regBC + ONE_W;
      SRC_BC_DEC:    nextVal = regBC - ONE_W;
      SRC_DE_INC:    nextVal = regDE + ONE_W;
      SRC_IMM_INC:   nextVal = imm16 + ONE_W;
      SRC_IMM:       nextVal = imm16;
      SRC_ACC_C:     nextVal = {regA, regBC[BYTE_W-1:0] + ONE_B};
      SRC_ACC_E:     nextVal = {regA, regDE[BYTE_W-1:0] + ONE_B};
      SRC_ACC_IMMLO: nextVal = {regA, imm16[BYTE_W-1:0] + ONE_B};
      SRC_ACC_PORT:  nextVal = {regA, imm8 + ONE_B};
      SRC_PORT_INC:  nextVal = accPort + ONE_W;
      SRC_REL:       nextVal = relTarget;
      SRC_STACK:     nextVal = stackWord;
      SRC_VEC:       nextVal = {{EXT_W{1'b0}}, imm8};
      SRC_HL_INC:    nextVal = regHL + ONE_W;
      SRC_IDX_INC:   nextVal = regIdx + ONE_W;
      SRC_CUR_INC:   nextVal = hidAddr + ONE_W;
      SRC_CUR_DEC:   nextVal = hidAddr - ONE_W;
      SRC_PC_INC:    nextVal = pcStart + ONE_W;
      SRC_BCA_INC:   nextVal = bcAfter + ONE_W;
      SRC_BCA_DEC:   nextVal = bcAfter - ONE_W;
      default:       nextVal = hidAddr;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hidAddr <= '0;
    else if (ctl.load) hidAddr <= nextVal;
  end

  assign flagBit5 = hidAddr[TAP_HI];
  assign flagBit3 = hidAddr[TAP_LO];

  AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> $stable(hidAddr)); // R1
  AST_CUR_STEP_UP: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && ctl.src == SRC_CUR_INC) |=> hidAddr == $past(hidAddr) + ONE_W); // R9
  AST_CUR_STEP_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && ctl.src == SRC_CUR_DEC) |=> hidAddr == $past(hidAddr) - ONE_W); // R9
endmodule

// File: rtl/haddr_tracker.sv
module haddr_tracker
  import haddr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              done,
  input  logic [CLS_W-1:0]  cls,
  input  logic [BYTE_W-1:0] regA,
  input  logic [ADDR_W-1:0] regBC,
  input  logic [ADDR_W-1:0] regDE,
  input  logic [ADDR_W-1:0] regHL,
  input  logic [ADDR_W-1:0] regIdx,
  input  logic [ADDR_W-1:0] pcStart,
  input  logic [BYTE_W-1:0] imm8,
  input  logic [ADDR_W-1:0] imm16,
  input  logic [ADDR_W-1:0] stackWord,
  input  logic [ADDR_W-1:0] bcAfter,
  input  logic              condMet,
  input  logic              bZeroAfter,
  input  logic              bcZeroAfter,
  input  logic              cmpMatch,
  output logic [ADDR_W-1:0] hidAddr,
  output logic              flagBit5,
  output logic              flagBit3
);
  haddrCtl_t ctl;

  haddr_ctrl ctrl_i (
    .done(done), .cls(cls), .condMet(condMet), .bZeroAfter(bZeroAfter),
    .bcZeroAfter(bcZeroAfter), .cmpMatch(cmpMatch), .ctl(ctl)
  );

  haddr_dpath dpath_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .regA(regA), .regBC(regBC),
    .regDE(regDE), .regHL(regHL), .regIdx(regIdx), .pcStart(pcStart),
    .imm8(imm8), .imm16(imm16), .stackWord(stackWord), .bcAfter(bcAfter),
    .hidAddr(hidAddr), .flagBit5(flagBit5), .flagBit3(flagBit3)
  );

  AST_JR_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (done && cls == CLS_JR_REL && !condMet) |=> $stable(hidAddr)); // R6
  AST_JP_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    (done && cls == CLS_JP_ABS) |=> hidAddr == $past(imm16)); // R6
  AST_STORE_ACC_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (done && cls == CLS_STA_BC) |=> hidAddr[ADDR_W-1:BYTE_W] == $past(regA)); // R4
  AST_COPY_DONE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (done && cls == CLS_COPY_R && bcZeroAfter) |=> $stable(hidAddr)); // R10
  AST_RET_CC_SKIP: assert property (@(posedge clk) disable iff (!rstN)
    (done && cls == CLS_RET_CC && !condMet) |=> $stable(hidAddr)); // R7
endmodule

// File: tb/haddr_tracker_tb_top.sv
`timescale 1ns/1ps
module haddr_tracker_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic done = 1'b0;
  logic [5:0]  cls = '0;
  logic [7:0]  regA = '0, imm8 = '0;
  logic [15:0] regBC = '0, regDE = '0, regHL = '0, regIdx = '0, pcStart = '0;
  logic [15:0] imm16 = '0, stackWord = '0, bcAfter = '0;
  logic condMet = 0, bZeroAfter = 0, bcZeroAfter = 0, cmpMatch = 0;
  logic [15:0] hidAddr;
  logic flagBit5, flagBit3;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [15:0] model = '0;

  always #5 clk = ~clk;

  haddr_tracker dut_i (
    .clk(clk), .rstN(rstN), .done(done), .cls(cls), .regA(regA), .regBC(regBC),
    .regDE(regDE), .regHL(regHL), .regIdx(regIdx), .pcStart(pcStart),
    .imm8(imm8), .imm16(imm16), .stackWord(stackWord), .bcAfter(bcAfter),
    .condMet(condMet), .bZeroAfter(bZeroAfter), .bcZeroAfter(bcZeroAfter),
    .cmpMatch(cmpMatch), .hidAddr(hidAddr), .flagBit5(flagBit5), .flagBit3(flagBit3)
  );

  function automatic string reqOf(int c);
    if (c == 1) return "R2";
    if (c == 2 || c == 3 || c == 4 || c == 11) return "R3";
    if (c >= 5 && c <= 8) return "R4";
    if (c == 9 || c == 10) return "R5";
    if (c >= 12 && c <= 14) return "R6";
    if (c >= 15 && c <= 18) return "R7";
    if (c >= 19 && c <= 21) return "R8";
    if (c >= 22 && c <= 25) return "R9";
    if (c == 26) return "R10";
    if (c >= 27 && c <= 34) return "R11";
    return "R1";
  endfunction

  function automatic logic [15:0] sx(logic [7:0] b);
    return {{8{b[7]}}, b};
  endfunction

  function automatic logic [15:0] expect_next(int c, logic [15:0] cur);
    bit cmpRep = !bcZeroAfter && !cmpMatch;
    bit bRep = !bZeroAfter;
    case (c)
      1:  return regIdx + sx(imm8);
      2:  return regBC + 16'd1;
      3:  return regDE + 16'd1;
      4, 11: return imm16 + 16'd1;
      5:  return {regA, 8'(regBC[7:0] + 8'd1)};
      6:  return {regA, 8'(regDE[7:0] + 8'd1)};
      7:  return {regA, 8'(imm16[7:0] + 8'd1)};
      8:  return {regA, 8'(imm8 + 8'd1)};
      9:  return (regA * 16'd256 + imm8) + 16'd1;
      10: return regBC + 16'd1;
      12: return imm16;
      13: return condMet ? pcStart + 16'd2 + sx(imm8) : cur;
      14: return bRep ? pcStart + 16'd2 + sx(imm8) : cur;
      15, 18: return stackWord;
      16: return condMet ? stackWord : cur;
      17: return {8'h00, imm8};
      19, 21: return regHL + 16'd1;
      20: return regIdx + 16'd1;
      22: return cur + 16'd1;
      23: return cur - 16'd1;
      24: return cmpRep ? pcStart + 16'd1 : cur + 16'd1;
      25: return cmpRep ? pcStart + 16'd1 : cur - 16'd1;
      26: return !bcZeroAfter ? pcStart + 16'd1 : cur;
      27: return regBC + 16'd1;
      28: return regBC - 16'd1;
      29: return bRep ? pcStart + 16'd1 : regBC + 16'd1;
      30: return bRep ? pcStart + 16'd1 : regBC - 16'd1;
      31: return bcAfter + 16'd1;
      32: return bcAfter - 16'd1;
      33: return bRep ? pcStart + 16'd1 : bcAfter + 16'd1;
      34: return bRep ? pcStart + 16'd1 : bcAfter - 16'd1;
      default: return cur;
    endcase
  endfunction

  task automatic check16(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s cls=%0d actual=%h expected=%h", req, what, cls, act, exp);
    end
  endtask

  task automatic check_taps();
    checks++;
    if (flagBit5 !== model[13] || flagBit3 !== model[11]) begin
      errors++;
      $display("FAIL R12 taps actual=%b%b expected=%b%b", flagBit5, flagBit3, model[13], model[11]);
    end
  endtask

  task automatic set_operands(int p, int c);
    int h;
    case (p)
      0: begin regA = 8'hFF; regBC = 16'hFFFF; regDE = 16'h12FF; regHL = 16'hFFFF;
               regIdx = 16'h0000; pcStart = 16'hFFFE; imm8 = 8'hFF; imm16 = 16'hFFFF;
               stackWord = 16'hA5A5; bcAfter = 16'h0000; end
      1: begin regA = 8'h00; regBC = 16'h0000; regDE = 16'h0000; regHL = 16'h7FFF;
               regIdx = 16'hFFFF; pcStart = 16'h0000; imm8 = 8'h80; imm16 = 16'h00FF;
               stackWord = 16'h2800; bcAfter = 16'hFFFF; end
      2: begin regA = 8'h7F; regBC = 16'h01FF; regDE = 16'hFEFF; regHL = 16'h0000;
               regIdx = 16'h7FFF; pcStart = 16'h7FFD; imm8 = 8'h7F; imm16 = 16'h1234;
               stackWord = 16'h0800; bcAfter = 16'h2000; end
      default: begin
        h = (p * 40503 + c * 977 + 12345) * 1103;
        regA = h[7:0]; regBC = h[23:8]; regDE = h[15:0] ^ 16'h5A5A;
        regHL = h[31:16]; regIdx = h[19:4]; pcStart = h[27:12];
        imm8 = h[11:4]; imm16 = h[15:0] + 16'h3C3C; stackWord = h[26:11];
        bcAfter = h[21:6];
      end
    endcase
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog expired actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    set_operands(0, 0);
    repeat (3) @(negedge clk);
    check16("R1", "reset", hidAddr, 16'h0000);
    check_taps();
    rstN = 1'b1;
    @(negedge clk);
    check16("R1", "after reset", hidAddr, 16'h0000);
    for (int c = 0; c < 64; c++) begin
      for (int f = 0; f < 16; f++) begin
        for (int p = 0; p < 5; p++) begin
          cls = 6'(c);
          {condMet, bZeroAfter, bcZeroAfter, cmpMatch} = 4'(f);
          set_operands(p, c);
          model = expect_next(c, model);
          done = 1'b1;
          @(negedge clk);
          done = 1'b0;
          check16(reqOf(c), "load", hidAddr, model);
          check_taps();
          set_operands(p + 7, c + f);
          @(negedge clk);
          check16("R1", "hold while idle", hidAddr, model);
        end
      end
    end
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule